// File: doc/BRIEF.md
# Interval Timer Count Latch and Status Read Path

This block is the host read side of a three-channel interval timer. Each channel's counting engine supplies a live 16-bit count and the level of its output pin. The block keeps the last control word of each channel. It takes two kinds of command. The first is a per-channel count snapshot, issued as a control word whose access field is zero. The second is a multi-channel read-back command that can freeze the count, the status, or both. Every read returns one byte on an 8-bit port, and the byte order follows the channel's programmed access mode.

A snapshot is held until the host has read all of it, while the live count keeps moving underneath. A status byte holds three things: the output level, a null-count flag and the channel's six control bits. The flag is raised by a count write and cleared once the counting engine takes that count in. When a status byte and a count are both held, the status byte is read first.

Top module: `tmr_rdback`

## Requirements
- R1: After a synchronous active-low reset, every channel has control bits 6'b110000 (low-then-high byte order), no held count, no held status, a clear null flag and its byte toggle pointing at the low byte.
- R2: The access field is control bits [5:4]. With 01 every read returns the low byte. With 10 every read returns the high byte. With 11 reads alternate: low byte first, then high byte.
- R3: A control word to a channel with a nonzero access field stores bits [5:0]. It returns the byte toggle to the low byte and discards any held count or status of that channel.
- R4: A control word with access field 00 latches the addressed channel's live count at that clock edge. Later reads return the latched bytes whatever the live count does. The latch is released after the last byte of the access mode is read: one byte for modes 01 and 10, two bytes for mode 11.
- R5: A count latch command (control word or read-back) that reaches a channel still holding an unread count is ignored.
- R6: A read-back strobe acts on every channel whose bit in `rb_sel` is set. `rb_cnt` latches the count and `rb_sts` latches the status. A status latch that reaches a channel still holding an unread status byte is ignored.
- R7: A status byte holds the following fields. Bit 7 is the channel's output level at the latch edge. Bit 6 is the null flag at that edge. Bits 5:0 are the channel's stored control bits.
- R8: While a status byte is held, the next read of that channel returns it and releases it without moving the byte toggle. Reads after that return count bytes.
- R9: A count write strobe sets the channel's null flag. A load strobe clears it at the next edge. When both strobes arrive in the same cycle, the flag stays set.
- R10: With nothing held, `rd_data` shows the selected byte of the live count in the same cycle, and a read with `rd_en` advances the toggle at the clock edge.
- R11: Channel index 3 selects no channel. A control word to it changes nothing, and reading it gives 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_wr | input | 1 | Control word strobe |
| ctl_ch | input | 2 | Channel addressed by the control word |
| ctl_bits | input | 6 | Control bits: [5:4] access, [3:1] mode, [0] decimal flag |
| rb_stb | input | 1 | Read-back command strobe |
| rb_sel | input | 3 | Channels addressed by the read-back command |
| rb_cnt | input | 1 | Read-back latches count |
| rb_sts | input | 1 | Read-back latches status |
| cnt_wr | input | 3 | Per channel: a new count was written |
| cnt_load | input | 3 | Per channel: the written count entered the counting engine |
| live_cnt | input | 48 | Live counts, channel k in bits [16k+15:16k] |
| out_lvl | input | 3 | Per channel output pin level |
| rd_en | input | 1 | Read strobe, consumes the byte shown on rd_data |
| rd_ch | input | 2 | Channel being read |
| rd_data | output | 8 | Byte presented for the selected channel |

## Verification
The bench builds the block with its defaults: three channels and a 2-bit channel index. This leaves one unused index value, so reads and control words aimed at a missing channel can be exercised. Three channels are enough for one read-back command to address a single channel while the other channels keep their own access modes. With them, the bench can show that a held snapshot, a dropped second latch and status-before-count ordering stay within the addressed channel.

// File: rtl/tmr_rdback_pkg.sv
// Shared definitions for the timer read path: byte and count widths,
// access-field encodings and the decoded per-channel command bundle.
package tmr_rdback_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int CTL_W  = 6;

    // Reset control bits: low-then-high access, mode 0, binary.
    localparam logic [CTL_W-1:0] CTL_RST = 6'b110000;

    typedef enum logic [1:0] {
        ACC_SNAP = 2'b00,
        ACC_LO   = 2'b01,
        ACC_HI   = 2'b10,
        ACC_WORD = 2'b11
    } acc_e;

    typedef struct packed {
        logic             cw_we;
        logic             lat_cnt;
        logic             lat_sts;
        logic [CTL_W-1:0] bits;
    } chan_cmd_t;

endpackage

// File: rtl/tmr_rdback_cmd.sv
// Command decoder. Turns the control-word and read-back strobes into one
// command bundle per channel. Assumes at most one control word per cycle.
// Channel indices at or above NUM_CH match nothing.
module tmr_rdback_cmd
    import tmr_rdback_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int SEL_W  = 2
) (
    input  logic                    ctl_wr,
    input  logic [SEL_W-1:0]        ctl_ch,
    input  logic [CTL_W-1:0]        ctl_bits,
    input  logic                    rb_stb,
    input  logic [NUM_CH-1:0]       rb_sel,
    input  logic                    rb_cnt,
    input  logic                    rb_sts,
    output chan_cmd_t [NUM_CH-1:0]  cmd_o
);

    acc_e acc;
    assign acc = acc_e'(ctl_bits[5:4]);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        chan_cmd_t one;
        logic      hit;

        assign hit = ctl_wr && (ctl_ch == SEL_W'(g));

        // Build the command for channel g from both command sources.
        always_comb begin
            one.cw_we   = hit && (acc != ACC_SNAP);
            one.lat_cnt = (hit && (acc == ACC_SNAP)) || (rb_stb && rb_sel[g] && rb_cnt);
            one.lat_sts = rb_stb && rb_sel[g] && rb_sts;
            one.bits    = ctl_bits;
        end

        assign cmd_o[g] = one;
    end

endmodule

// File: rtl/tmr_rdback_chan.sv
// One channel of the read path. Holds the control bits, the null flag,
// the count and status snapshots and the byte toggle, and presents the
// next byte to read. Assumes rd_sel is high only for a real read of
// this channel.
module tmr_rdback_chan
    import tmr_rdback_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  chan_cmd_t         cmd_i,
    input  logic              cnt_wr,
    input  logic              cnt_load,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic              out_lvl,
    input  logic              rd_sel,
    output logic [BYTE_W-1:0] rd_byte
);

    logic [CTL_W-1:0]  ctl_q;
    logic              null_q;
    logic              tog_q;
    logic              cnt_held_q;
    logic [CNT_W-1:0]  cnt_hold_q;
    logic              sts_held_q;
    logic [BYTE_W-1:0] sts_hold_q;

    acc_e              acc;
    logic [CNT_W-1:0]  src;
    logic              take_hi;
    logic              cnt_rd;
    logic              cnt_done;

    // Select the byte to present and work out whether this read ends a count.
    always_comb begin
        acc      = acc_e'(ctl_q[5:4]);
        src      = cnt_held_q ? cnt_hold_q : live_cnt;
        take_hi  = (acc == ACC_HI) || ((acc == ACC_WORD) && tog_q);
        rd_byte  = sts_held_q ? sts_hold_q
                 : (take_hi ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0]);
        cnt_rd   = rd_sel && !sts_held_q;
        cnt_done = cnt_rd && ((acc != ACC_WORD) || tog_q);
    end

    // Null flag: set by a count write, cleared when the count is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n)        null_q <= 1'b0;
        else if (cnt_wr)   null_q <= 1'b1;
        else if (cnt_load) null_q <= 1'b0;
    end

    // Control bits and the byte toggle of two-byte access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
            tog_q <= 1'b0;
        end else if (cmd_i.cw_we) begin
            ctl_q <= cmd_i.bits;
            tog_q <= 1'b0;
        end else if (cnt_rd && (acc == ACC_WORD)) begin
            tog_q <= !tog_q;
        end
    end

    // Count snapshot: taken once, held until fully read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_held_q <= 1'b0;
            cnt_hold_q <= '0;
        end else if (cmd_i.cw_we) begin
            cnt_held_q <= 1'b0;
        end else if (cmd_i.lat_cnt && !cnt_held_q) begin
            cnt_held_q <= 1'b1;
            cnt_hold_q <= live_cnt;
        end else if (cnt_done) begin
            cnt_held_q <= 1'b0;
        end
    end

    // Status snapshot: output level, null flag and control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_held_q <= 1'b0;
            sts_hold_q <= '0;
        end else if (cmd_i.cw_we) begin
            sts_held_q <= 1'b0;
        end else if (cmd_i.lat_sts && !sts_held_q) begin
            sts_held_q <= 1'b1;
            sts_hold_q <= {out_lvl, null_q, ctl_q};
        end else if (rd_sel && sts_held_q) begin
            sts_held_q <= 1'b0;
        end
    end

    AST_NULL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(null_q) |-> $past(cnt_wr)); // R9

    AST_NULL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(null_q) |-> ($past(cnt_load) && !$past(cnt_wr))); // R9

    AST_TOG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.cw_we |=> !tog_q); // R3

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_held_q && !cnt_done && !cmd_i.cw_we) |=> (cnt_held_q && $stable(cnt_hold_q))); // R5

    AST_STS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_held_q && !rd_sel && !cmd_i.cw_we) |=> (sts_held_q && $stable(sts_hold_q))); // R6

    AST_STS_NO_TOG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel && sts_held_q && !cmd_i.cw_we) |=> $stable(tog_q)); // R8

endmodule

// File: rtl/tmr_rdback.sv
// Top of the timer read path. Decodes commands, keeps one read channel
// per timer channel and multiplexes the addressed channel's byte onto the
// read port. Assumes the counting engine drives live_cnt and out_lvl.
module tmr_rdback
    import tmr_rdback_pkg::*;
#(
    parameter  int NUM_CH = 3,
    localparam int SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH + 1) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ctl_wr,
    input  logic [SEL_W-1:0]        ctl_ch,
    input  logic [CTL_W-1:0]        ctl_bits,
    input  logic                    rb_stb,
    input  logic [NUM_CH-1:0]       rb_sel,
    input  logic                    rb_cnt,
    input  logic                    rb_sts,
    input  logic [NUM_CH-1:0]       cnt_wr,
    input  logic [NUM_CH-1:0]       cnt_load,
    input  logic [NUM_CH*CNT_W-1:0] live_cnt,
    input  logic [NUM_CH-1:0]       out_lvl,
    input  logic                    rd_en,
    input  logic [SEL_W-1:0]        rd_ch,
    output logic [BYTE_W-1:0]       rd_data
);

    chan_cmd_t [NUM_CH-1:0]  cmd;
    logic [BYTE_W-1:0]       chan_byte [NUM_CH];

    tmr_rdback_cmd #(
        .NUM_CH (NUM_CH),
        .SEL_W  (SEL_W)
    ) i_cmd (
        .ctl_wr   (ctl_wr),
        .ctl_ch   (ctl_ch),
        .ctl_bits (ctl_bits),
        .rb_stb   (rb_stb),
        .rb_sel   (rb_sel),
        .rb_cnt   (rb_cnt),
        .rb_sts   (rb_sts),
        .cmd_o    (cmd)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic sel;
        assign sel = rd_en && (rd_ch == SEL_W'(g));

        tmr_rdback_chan i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd_i    (cmd[g]),
            .cnt_wr   (cnt_wr[g]),
            .cnt_load (cnt_load[g]),
            .live_cnt (live_cnt[g*CNT_W +: CNT_W]),
            .out_lvl  (out_lvl[g]),
            .rd_sel   (sel),
            .rd_byte  (chan_byte[g])
        );
    end

    // Read multiplexer; an index with no channel behind it reads as zero.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (rd_ch == SEL_W'(k)) rd_data = chan_byte[k];
        end
    end

endmodule

// File: tb/test_tmr_rdback.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, the unused channel index, a dropped status latch and
// coinciding write and load strobes.
module test_tmr_rdback;

    localparam int NCH = 3;
    localparam int SW  = 2;

    localparam logic [2:0] OP_NOP = 3'd0;
    localparam logic [2:0] OP_RD  = 3'd1;
    localparam logic [2:0] OP_CW  = 3'd2;
    localparam logic [2:0] OP_RB  = 3'd3;
    localparam logic [2:0] OP_WR  = 3'd4;
    localparam logic [2:0] OP_LD  = 3'd5;

    // {req[3:0], op[2:0], ch[1:0], arg[7:0], out[2:0], live[15:0], exp[7:0]}
    localparam int VW = 44;
    localparam int NV = 30;
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'd1,  OP_RD, 2'd0, 8'h00, 3'b000, 16'h1234, 8'h34}, // R1 reset order, low byte
        {4'd2,  OP_RD, 2'd0, 8'h00, 3'b000, 16'h1234, 8'h12}, // R2 then high byte
        {4'd4,  OP_CW, 2'd0, 8'h00, 3'b000, 16'hABCD, 8'h00}, // R4 snapshot
        {4'd4,  OP_RD, 2'd0, 8'h00, 3'b000, 16'h5555, 8'hCD}, // R4 held low byte
        {4'd5,  OP_CW, 2'd0, 8'h00, 3'b000, 16'h7777, 8'h00}, // R5 second snapshot
        {4'd5,  OP_RD, 2'd0, 8'h00, 3'b000, 16'h6666, 8'hAB}, // R5 old high byte
        {4'd4,  OP_RD, 2'd0, 8'h00, 3'b000, 16'h6666, 8'h66}, // R4 released
        {4'd10, OP_RD, 2'd0, 8'h00, 3'b000, 16'h6666, 8'h66}, // R10 live high
        {4'd2,  OP_CW, 2'd1, 8'h14, 3'b000, 16'h0000, 8'h00}, // R2 ch1 low only
        {4'd2,  OP_RD, 2'd1, 8'h00, 3'b000, 16'h2000, 8'h01}, // R2
        {4'd2,  OP_RD, 2'd1, 8'h00, 3'b000, 16'h2000, 8'h01}, // R2 no toggle
        {4'd2,  OP_CW, 2'd1, 8'h25, 3'b000, 16'h0000, 8'h00}, // R2 ch1 high only
        {4'd2,  OP_RD, 2'd1, 8'h00, 3'b000, 16'h4000, 8'h40}, // R2
        {4'd9,  OP_WR, 2'd2, 8'h00, 3'b000, 16'h0000, 8'h00}, // R9 set null
        {4'd6,  OP_RB, 2'd0, 8'h1C, 3'b100, 16'h9000, 8'h00}, // R6 count and status ch2
        {4'd8,  OP_RD, 2'd2, 8'h00, 3'b000, 16'h0000, 8'hF0}, // R8 R7 status first
        {4'd6,  OP_RD, 2'd2, 8'h00, 3'b000, 16'h0000, 8'h02}, // R6 held low
        {4'd6,  OP_RD, 2'd2, 8'h00, 3'b000, 16'h0000, 8'h90}, // R6 held high
        {4'd9,  OP_LD, 2'd2, 8'h00, 3'b000, 16'h0000, 8'h00}, // R9 load
        {4'd7,  OP_RB, 2'd0, 8'h14, 3'b000, 16'h0000, 8'h00}, // R7 status only
        {4'd9,  OP_RD, 2'd2, 8'h00, 3'b000, 16'h0000, 8'h30}, // R9 null cleared
        {4'd10, OP_RD, 2'd2, 8'h00, 3'b000, 16'h0102, 8'h04}, // R10 live low
        {4'd10, OP_RD, 2'd2, 8'h00, 3'b000, 16'h0102, 8'h01}, // R10 live high
        {4'd3,  OP_RD, 2'd0, 8'h00, 3'b000, 16'h3344, 8'h44}, // R3 toggle now high
        {4'd3,  OP_CW, 2'd0, 8'h30, 3'b000, 16'h0000, 8'h00}, // R3 rewrite
        {4'd3,  OP_RD, 2'd0, 8'h00, 3'b000, 16'h3344, 8'h44}, // R3 back to low
        {4'd3,  OP_CW, 2'd0, 8'h00, 3'b000, 16'h1111, 8'h00}, // R3 snapshot
        {4'd3,  OP_CW, 2'd0, 8'h30, 3'b000, 16'h0000, 8'h00}, // R3 discard it
        {4'd3,  OP_RD, 2'd0, 8'h00, 3'b000, 16'h2222, 8'h22}, // R3 live low
        {4'd3,  OP_RD, 2'd0, 8'h00, 3'b000, 16'h2222, 8'h22}  // R3 live high
    };

    logic                clk = 1'b0;
    logic                rst_n;
    logic                ctl_wr;
    logic [SW-1:0]       ctl_ch;
    logic [5:0]          ctl_bits;
    logic                rb_stb;
    logic [NCH-1:0]      rb_sel;
    logic                rb_cnt;
    logic                rb_sts;
    logic [NCH-1:0]      cnt_wr;
    logic [NCH-1:0]      cnt_load;
    logic [NCH*16-1:0]   live_cnt;
    logic [NCH-1:0]      out_lvl;
    logic                rd_en;
    logic [SW-1:0]       rd_ch;
    logic [7:0]          rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = !clk;

    tmr_rdback #(.NUM_CH(NCH)) i_tmr_rdback (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_ch   (ctl_ch),
        .ctl_bits (ctl_bits),
        .rb_stb   (rb_stb),
        .rb_sel   (rb_sel),
        .rb_cnt   (rb_cnt),
        .rb_sts   (rb_sts),
        .cnt_wr   (cnt_wr),
        .cnt_load (cnt_load),
        .live_cnt (live_cnt),
        .out_lvl  (out_lvl),
        .rd_en    (rd_en),
        .rd_ch    (rd_ch),
        .rd_data  (rd_data)
    );

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Drive one vector at the falling edge and compare reads before the rise.
    task automatic apply(input logic [VW-1:0] v, input int idx);
        logic [3:0]  req;
        logic [2:0]  op;
        logic [1:0]  ch;
        logic [7:0]  arg;
        logic [2:0]  out;
        logic [15:0] live;
        logic [7:0]  exp;
        {req, op, ch, arg, out, live, exp} = v;
        @(negedge clk);
        ctl_wr   = (op == OP_CW);
        ctl_ch   = ch;
        ctl_bits = arg[5:0];
        rb_stb   = (op == OP_RB);
        rb_sel   = arg[2:0];
        rb_cnt   = arg[3];
        rb_sts   = arg[4];
        cnt_wr   = (op == OP_WR) ? 3'(1 << ch) : 3'b000;
        cnt_load = (op == OP_LD) ? 3'(1 << ch) : 3'b000;
        out_lvl  = out;
        live_cnt = {live + 16'd2, live + 16'd1, live};
        rd_en    = (op == OP_RD);
        rd_ch    = ch;
        #2;
        if (op == OP_RD) begin
            n_chk++;
            if (rd_data !== exp) begin
                n_bad++;
                $display("FAIL step %0d R%0d: rd_data=%02h expected %02h", idx, req, rd_data, exp);
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog R1: run did not finish, actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        apply({4'd0, OP_NOP, 2'd0, 8'h00, 3'b000, 16'h0000, 8'h00}, -1);
        apply({4'd0, OP_NOP, 2'd0, 8'h00, 3'b000, 16'h0000, 8'h00}, -1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) apply(VEC[i], i);

        // R1: a snapshot held across a reset is dropped, order restarts low.
        apply({4'd1, OP_CW, 2'd0, 8'h00, 3'b000, 16'hBEEF, 8'h00}, 100);
        rst_n = 1'b0;
        apply({4'd1, OP_NOP, 2'd0, 8'h00, 3'b000, 16'h0000, 8'h00}, 101);
        rst_n = 1'b1;
        apply({4'd1, OP_RD, 2'd0, 8'h00, 3'b000, 16'h0A0B, 8'h0B}, 102);
        apply({4'd1, OP_RD, 2'd0, 8'h00, 3'b000, 16'h0A0B, 8'h0A}, 103);

        // R11: index 3 reads zero and a control word to it changes nothing.
        apply({4'd11, OP_RD, 2'd3, 8'h00, 3'b000, 16'h5A6B, 8'h00}, 110);
        apply({4'd11, OP_CW, 2'd3, 8'h14, 3'b000, 16'h0000, 8'h00}, 111);
        apply({4'd11, OP_RD, 2'd0, 8'h00, 3'b000, 16'h5A6B, 8'h6B}, 112);
        apply({4'd11, OP_RD, 2'd0, 8'h00, 3'b000, 16'h5A6B, 8'h5A}, 113);

        // R6: second status latch to ch1 is dropped; ch1 is high-only.
        apply({4'd6, OP_CW, 2'd1, 8'h25, 3'b000, 16'h0000, 8'h00}, 120);
        apply({4'd6, OP_RB, 2'd0, 8'h12, 3'b010, 16'h0000, 8'h00}, 121);
        apply({4'd6, OP_RB, 2'd0, 8'h12, 3'b000, 16'h0000, 8'h00}, 122);
        apply({4'd6, OP_RD, 2'd1, 8'h00, 3'b000, 16'h4000, 8'hA5}, 123);
        apply({4'd8, OP_RD, 2'd1, 8'h00, 3'b000, 16'h4000, 8'h40}, 124);

        // R9: write and load in one cycle leave the null flag set.
        @(negedge clk);
        cnt_wr   = 3'b010;
        cnt_load = 3'b010;
        rd_en    = 1'b0;
        apply({4'd9, OP_RB, 2'd0, 8'h12, 3'b000, 16'h0000, 8'h00}, 130);
        apply({4'd9, OP_RD, 2'd1, 8'h00, 3'b000, 16'h0000, 8'h65}, 131);

        apply({4'd0, OP_NOP, 2'd0, 8'h00, 3'b000, 16'h0000, 8'h00}, -1);
        finish_run();
    end

endmodule